// File: doc/BRIEF.md
# Bit-Serial Bus Nonvolatile Memory Controller

This block is the device side of a byte-organised nonvolatile memory that a host reaches through ordinary bus cycles carried on one data line. Each host cycle is framed by three active-low strobes: chip select, output enable and write enable. A write cycle hands the block one bit. A read cycle takes one bit from it. Every operation is built from patterns of these single-bit cycles: arming, address loading, sequential reading, page loading and starting a nonvolatile write. No opcode byte and no serial clock are involved.

The strobes, the data input and the write-protect pin pass through a synchroniser into the system clock domain. Cycle ends are found by edge detection on the combined strobes, and each one becomes a read event, a write-0 event or a write-1 event. A sequencer turns these events into address, page-buffer and latch actions. A clock-cycle timer models the nonvolatile write time. When the timer runs out, the bytes loaded into the page buffer are copied into an on-chip array, which starts with every byte at 0xFF. The output-enable of the data pin follows the raw strobes, so the pin is released as soon as the host releases the bus.

Top module: `bitser_nvmem`

## Requirements
- R1: `io_oe` is 1 exactly while `ce_n` and `oe_n` are both 0, and 0 in every other strobe combination.
- R2: The event pattern read, write-0, read resets the sequencer and arms it for an address. Its final read returns 1, and so does every later read until 16 address bits have been loaded.
- R3: The address is 16 write cycles, most significant bit first. If the first bit (bit 15) is 1, the array is not selected and the following reads return 1.
- R4: After the address, each run of 8 reads returns one byte, bit 7 first, and the address then increments. At the top address of the array, the address rolls over to 0.
- R5: A write-1 right after the 8th bit of a byte ends the read, and later reads return 1.
- R6: Arm, 16 address bits, one or more whole data bytes, then read, write-1, read starts a nonvolatile write. Once the write completes, the loaded bytes are in the array.
- R7: Data bytes fill a 64-byte page selected by the upper address bits. Loading past offset 63 wraps to offset 0 of the same page, and later bytes overwrite earlier ones.
- R8: A write starts only when the write-enable latch is set. A partial byte, or a load cut short, clears the latch and starts nothing.
- R9: While a write runs, every read returns 0, including the reads of an arming sequence. That sequence does not abort the write, and reads return 1 once the write is done.
- R10: With `wp_n` low, the start command starts nothing. Pulling `wp_n` low during a running write does not stop that write.
- R11: Read, read, write-1 after the data bytes starts nothing. Read, write-0, write-0 sends the sequencer idle, where reads return 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| io_in | input | 1 | Data line value driven by the host |
| io_out | output | 1 | Data or status bit driven toward the host |
| io_oe | output | 1 | Drive enable for the data line |
| wp_n | input | 1 | Write protect, active low |

## Verification
The hardest state to reach is an arming sequence that arrives while a nonvolatile write is still running. The bench reaches it by starting a page write and immediately issuing read, write-0, read. Every read in that window must return 0, and the page must still land in the array. Page wrap also needs a long stimulus: the bench loads 66 bytes starting two bytes below a page end and compares the whole page against a bench model. Constrained-random page writes with random addresses and byte counts, each read back byte by byte, cover the rest.

// File: rtl/bitser_pkg.sv
`timescale 1ns/1ps
package bitser_pkg;
  typedef enum logic [1:0] {EV_NONE, EV_RD, EV_W0, EV_W1} ev_t;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RDATA, ST_LOAD, ST_LEND, ST_LEND1, ST_BRK
  } st_t;
endpackage

// File: rtl/bitser_sync.sv
`timescale 1ns/1ps
module bitser_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              io_in,
  input  logic              wp_n,
  output bitser_pkg::ev_t   ev,
  output logic              wp_ok
);
  import bitser_pkg::*;
  localparam int NS = 5;

  logic [NS-1:0] pipe [STAGES];
  logic [NS-1:0] s;
  logic wr_act, rd_act, wr_q, rd_q, io_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= {wp_n, io_in, we_n, oe_n, ce_n};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign s      = pipe[STAGES-1];
  assign wr_act = !s[0] && !s[2] && s[1];
  assign rd_act = !s[0] && !s[1] && s[2];
  assign wp_ok  = s[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      io_hold <= 1'b1;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act) io_hold <= s[3];
    end
  end

  always_comb begin
    ev = EV_NONE;
    if (wr_q && !wr_act)      ev = io_hold ? EV_W1 : EV_W0;
    else if (rd_q && !rd_act) ev = EV_RD;
  end
endmodule

// File: rtl/bitser_seq.sv
`timescale 1ns/1ps
module bitser_seq #(
  parameter int ADDR_BITS = 16,
  parameter int MEM_AW    = 9,
  parameter int PAGE_AW   = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  bitser_pkg::ev_t             ev,
  input  logic                        wp_ok,
  input  logic                        busy,
  input  logic                        wr_done,
  output logic                        wel,
  output logic                        start,
  output logic                        buf_clr,
  output logic                        ld_en,
  output logic [PAGE_AW-1:0]          ld_idx,
  output logic [7:0]                  ld_byte,
  output logic [MEM_AW-PAGE_AW-1:0]   wr_page,
  output logic [MEM_AW-1:0]           rd_addr,
  output logic                        rd_sel,
  output logic [2:0]                  bit_idx
);
  import bitser_pkg::*;
  localparam int CW = $clog2(ADDR_BITS);

  st_t                  st;
  ev_t                  h_new, h_old;
  logic [ADDR_BITS-1:0] addr_q, newaddr;
  logic [CW-1:0]        cnt;
  logic [7:0]           shreg;
  logic                 rd_bnd, got_byte;
  logic                 is_w, b, rst_hit, rd_any;

  assign is_w    = (ev == EV_W0) || (ev == EV_W1);
  assign b       = (ev == EV_W1);
  assign rst_hit = (ev == EV_RD) && (h_new == EV_W0) && (h_old == EV_RD);
  assign newaddr = {addr_q[ADDR_BITS-2:0], b};
  assign rd_any  = (cnt != '0) || rd_bnd;

  assign start   = (ev == EV_RD) && !rst_hit && (st == ST_LEND1) && wel && wp_ok && !busy;
  assign ld_en   = is_w && (st == ST_LOAD) && (cnt == CW'(7));
  assign ld_byte = {shreg[6:0], b};
  assign ld_idx  = addr_q[PAGE_AW-1:0];
  assign buf_clr = is_w && (st == ST_RDATA) && !rd_any && wel && !busy;
  assign wr_page = addr_q[MEM_AW-1:PAGE_AW];
  assign rd_addr = addr_q[MEM_AW-1:0];
  assign rd_sel  = (st == ST_RDATA);
  assign bit_idx = 3'd7 - cnt[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      h_new    <= EV_NONE;
      h_old    <= EV_NONE;
      addr_q   <= '0;
      cnt      <= '0;
      shreg    <= '0;
      rd_bnd   <= 1'b0;
      got_byte <= 1'b0;
      wel      <= 1'b0;
    end else begin
      if (ev != EV_NONE) begin
        h_new <= ev;
        h_old <= h_new;
        if (rst_hit) begin
          st  <= ST_ADDR;
          cnt <= '0;
          if (!busy) wel <= 1'b1;
        end else begin
          unique case (st)
            ST_IDLE: ;
            ST_ADDR: begin
              if (is_w) begin
                addr_q <= newaddr;
                if (cnt == CW'(ADDR_BITS-1)) begin
                  cnt    <= '0;
                  rd_bnd <= 1'b0;
                  st     <= newaddr[ADDR_BITS-1] ? ST_IDLE : ST_RDATA;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end else begin
                st <= ST_BRK;
              end
            end
            ST_RDATA: begin
              if (ev == EV_RD) begin
                if (cnt == CW'(7)) begin
                  cnt                 <= '0;
                  rd_bnd              <= 1'b1;
                  addr_q[MEM_AW-1:0]  <= addr_q[MEM_AW-1:0] + 1'b1;
                end else begin
                  cnt    <= cnt + 1'b1;
                  rd_bnd <= 1'b0;
                end
              end else if (!rd_any) begin
                if (wel && !busy) begin
                  st       <= ST_LOAD;
                  cnt      <= CW'(1);
                  shreg    <= {7'd0, b};
                  got_byte <= 1'b0;
                end else begin
                  st  <= ST_IDLE;
                  wel <= 1'b0;
                end
              end else if (b) begin
                st <= ST_IDLE;
              end else begin
                st <= ST_BRK;
              end
            end
            ST_LOAD: begin
              if (is_w) begin
                shreg <= ld_byte;
                if (cnt == CW'(7)) begin
                  cnt                  <= '0;
                  got_byte             <= 1'b1;
                  addr_q[PAGE_AW-1:0]  <= addr_q[PAGE_AW-1:0] + 1'b1;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end else if (cnt == '0 && got_byte) begin
                st <= ST_LEND;
              end else begin
                st  <= ST_BRK;
                wel <= 1'b0;
              end
            end
            ST_LEND: begin
              if (ev == EV_W1)      st <= ST_LEND1;
              else if (ev == EV_W0) st <= ST_BRK;
              else begin
                st  <= ST_IDLE;
                wel <= 1'b0;
              end
            end
            ST_LEND1: begin
              st <= ST_IDLE;
              if (!start) wel <= 1'b0;
            end
            default: begin
              st  <= ST_IDLE;
              wel <= 1'b0;
            end
          endcase
        end
      end
      if (wr_done) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/bitser_core.sv
`timescale 1ns/1ps
module bitser_core #(
  parameter int MEM_AW    = 9,
  parameter int PAGE_AW   = 6,
  parameter int WR_CYCLES = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [MEM_AW-PAGE_AW-1:0]  wr_page,
  input  logic                       buf_clr,
  input  logic                       ld_en,
  input  logic [PAGE_AW-1:0]         ld_idx,
  input  logic [7:0]                 ld_byte,
  input  logic [MEM_AW-1:0]          rd_addr,
  output logic [7:0]                 rd_byte,
  output logic                       busy,
  output logic                       wr_done
);
  localparam int DEPTH = 2 ** MEM_AW;
  localparam int PB    = 2 ** PAGE_AW;
  localparam int TW    = $clog2(WR_CYCLES + 1);
  localparam int GW    = MEM_AW - PAGE_AW;

  logic [7:0]    mem  [DEPTH];
  logic [7:0]    pbuf [PB];
  logic [PB-1:0] mask;
  logic [TW-1:0] tmr;
  logic [GW-1:0] page_q;

  assign wr_done = busy && (tmr == '0);
  assign rd_byte = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tmr    <= '0;
      page_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      tmr    <= TW'(WR_CYCLES - 1);
      page_q <= wr_page;
    end else if (wr_done) begin
      busy <= 1'b0;
    end else if (busy) begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      for (int i = 0; i < PB; i++) pbuf[i] <= 8'hFF;
    end else if (buf_clr) begin
      mask <= '0;
    end else if (ld_en) begin
      pbuf[ld_idx] <= ld_byte;
      mask[ld_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_done) begin
      for (int i = 0; i < PB; i++)
        if (mask[i]) mem[{page_q, PAGE_AW'(i)}] <= pbuf[i];
    end
  end
endmodule

// File: rtl/bitser_nvmem.sv
`timescale 1ns/1ps
module bitser_nvmem #(
  parameter int ADDR_BITS   = 16,
  parameter int MEM_AW      = 9,
  parameter int PAGE_AW     = 6,
  parameter int WR_CYCLES   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic io_in,
  output logic io_out,
  output logic io_oe,
  input  logic wp_n
);
  import bitser_pkg::*;
  localparam int GW = MEM_AW - PAGE_AW;

  ev_t               ev;
  logic              wp_s, busy, wel, wr_done, start, buf_clr, ld_en, rd_sel;
  logic [PAGE_AW-1:0] ld_idx;
  logic [7:0]        ld_byte, rd_byte;
  logic [GW-1:0]     wr_page;
  logic [MEM_AW-1:0] rd_addr;
  logic [2:0]        bit_idx;

  bitser_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .io_in(io_in), .wp_n(wp_n), .ev(ev), .wp_ok(wp_s)
  );

  bitser_seq #(.ADDR_BITS(ADDR_BITS), .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .wp_ok(wp_s), .busy(busy),
    .wr_done(wr_done), .wel(wel), .start(start), .buf_clr(buf_clr),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_byte(ld_byte), .wr_page(wr_page),
    .rd_addr(rd_addr), .rd_sel(rd_sel), .bit_idx(bit_idx)
  );

  bitser_core #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_page(wr_page),
    .buf_clr(buf_clr), .ld_en(ld_en), .ld_idx(ld_idx), .ld_byte(ld_byte),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .busy(busy), .wr_done(wr_done)
  );

  assign io_oe  = !ce_n && !oe_n;
  assign io_out = !busy && (rd_sel ? rd_byte[bit_idx] : 1'b1);
endmodule

// File: rtl/bitser_nvmem_chk.sv
`timescale 1ns/1ps
module bitser_nvmem_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic wel,
  input logic wp_s,
  input logic wr_done
);
  // R10
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wp_s) |=> !busy);
  // R8
  armed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  // R8
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R9
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_done) |=> busy);
endmodule

bind bitser_nvmem bitser_nvmem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .wp_s(wp_s), .wr_done(wr_done)
);

// File: tb/bitser_nvmem_test.sv
`timescale 1ns/1ps
module bitser_nvmem_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, io_in = 1'b1, wp_n = 1'b1;
  logic io_out, io_oe;

  always #2.5 clk = ~clk;

  bitser_nvmem uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .wp_n(wp_n)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] mem_m [512];
  logic [7:0] dbuf [128];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit b);
    io_in = b; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 ce_n = 1'b1; we_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic rd(output bit v);
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    v = io_out;
    chk(io_oe === 1'b1, "R1 drive during read", io_oe, 1);
    @(posedge clk);
    #1 ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic arm(output bit v);
    bit t;
    rd(t); wr(1'b0); rd(v);
  endtask

  task automatic send_addr(input logic [15:0] a);
    for (int i = 15; i >= 0; i--) wr(a[i]);
  endtask

  task automatic get_byte(output logic [7:0] d);
    bit v;
    for (int i = 7; i >= 0; i--) begin rd(v); d[i] = v; end
  endtask

  task automatic put_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) wr(d[i]);
  endtask

  task automatic page_write(input logic [15:0] a, input int n);
    bit v;
    arm(v);
    send_addr(a);
    for (int k = 0; k < n; k++) put_byte(dbuf[k]);
    rd(v); wr(1'b1); rd(v);
  endtask

  function automatic void model_apply(input int a, input int n);
    for (int k = 0; k < n; k++)
      mem_m[(a & 9'h1C0) | ((a + k) & 6'h3F)] = dbuf[k];
  endfunction

  task automatic wait_done(input string req);
    bit v = 1'b0;
    int polls = 0;
    while (!v && polls < 100) begin rd(v); polls++; end
    chk(v, req, v, 1);
  endtask

  task automatic verify(input int a, input int n, input string req);
    bit v;
    logic [7:0] d;
    arm(v);
    send_addr(16'(a));
    for (int k = 0; k < n; k++) begin
      get_byte(d);
      chk(d === mem_m[(a + k) % 512], req, d, mem_m[(a + k) % 512]);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit v, v2;
    logic [7:0] d;
    int a, n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state and non-read strobe combinations
    chk(io_oe === 1'b0, "R1 idle release", io_oe, 0);
    ce_n = 1'b1; oe_n = 1'b0; #2;
    chk(io_oe === 1'b0, "R1 oe without ce", io_oe, 0);
    oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; #2;
    chk(io_oe === 1'b0, "R1 write cycle", io_oe, 0);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    rd(v);
    chk(v == 1'b1, "R2 idle read after reset", v, 1);

    // R2: arming returns 1 and keeps returning 1 before an address
    arm(v);
    chk(v == 1'b1, "R2 arm final read", v, 1);
    rd(v);
    chk(v == 1'b1, "R2 read before address", v, 1);

    // R6 / R9: directed write at 0x010
    dbuf[0] = 8'h00; dbuf[1] = 8'h00; dbuf[2] = 8'h5A;
    page_write(16'h0010, 3);
    model_apply(16'h0010, 3);
    rd(v);
    chk(v == 1'b0, "R9 busy read", v, 0);
    wait_done("R9 done status");
    verify(16'h0010, 3, "R6 readback");

    // R3: bit 15 set deselects the array
    arm(v); send_addr(16'h8010); get_byte(d);
    chk(d == 8'hFF, "R3 deselected", d, 8'hFF);

    // R5: write-1 after a byte ends the read
    arm(v); send_addr(16'h0010); get_byte(d);
    chk(d == 8'h00, "R4 first byte", d, 0);
    wr(1'b1); rd(v);
    chk(v == 1'b1, "R5 read ended", v, 1);

    // R11: read, write-0, write-0 goes idle
    arm(v); send_addr(16'h0010); get_byte(d);
    wr(1'b0); wr(1'b0); rd(v);
    chk(v == 1'b1, "R11 rww idle", v, 1);

    // R4: rollover from top address
    dbuf[0] = 8'h3C; page_write(16'h01FF, 1); model_apply(16'h01FF, 1);
    wait_done("R9 done status");
    dbuf[0] = 8'hC3; page_write(16'h0000, 1); model_apply(16'h0000, 1);
    wait_done("R9 done status");
    verify(16'h01FF, 2, "R4 rollover");

    // R7: 66 bytes from offset 62 of page 2 wrap in the page
    for (int k = 0; k < 66; k++) dbuf[k] = 8'($urandom);
    page_write(16'h00BE, 66); model_apply(16'h00BE, 66);
    wait_done("R9 done status");
    verify(16'h0080, 64, "R7 page wrap");

    // R8: partial byte never starts a write
    arm(v); send_addr(16'h0100);
    for (int k = 0; k < 4; k++) wr(1'b0);
    rd(v); wr(1'b1); rd(v); rd(v);
    chk(v == 1'b1, "R8 partial no busy", v, 1);
    verify(16'h0100, 1, "R8 array unchanged");

    // R11: read, read, write-1 after data starts nothing
    arm(v); send_addr(16'h0100); put_byte(8'h00);
    rd(v); rd(v); wr(1'b1); rd(v); rd(v);
    chk(v == 1'b1, "R11 rrw1 no busy", v, 1);
    verify(16'h0100, 1, "R11 array unchanged");

    // R10: protect blocks start
    wp_n = 1'b0;
    dbuf[0] = 8'h00; page_write(16'h0101, 1); rd(v);
    chk(v == 1'b1, "R10 protected no busy", v, 1);
    wp_n = 1'b1;
    verify(16'h0101, 1, "R10 array unchanged");

    // R10: protect during a write does not stop it
    dbuf[0] = 8'h42; page_write(16'h0102, 1); model_apply(16'h0102, 1);
    wp_n = 1'b0; rd(v);
    chk(v == 1'b0, "R10 busy with protect low", v, 0);
    wait_done("R10 done");
    wp_n = 1'b1;
    verify(16'h0102, 1, "R10 write kept");

    // R9: arming during a write reads 0 and does not abort
    dbuf[0] = 8'h11; page_write(16'h0103, 1); model_apply(16'h0103, 1);
    rd(v); wr(1'b0); rd(v2);
    chk(v == 1'b0, "R9 arm read during write", v, 0);
    chk(v2 == 1'b0, "R9 arm final read during write", v2, 0);
    wait_done("R9 done after arm");
    verify(16'h0103, 1, "R9 write not aborted");

    // R6: constrained random page writes
    for (int it = 0; it < 6; it++) begin
      a = int'($urandom % 512);
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
      page_write(16'(a), n); model_apply(a, n);
      rd(v);
      chk(v == 1'b0, "R9 random busy", v, 0);
      wait_done("R9 random done");
      verify(a, n, "R6 random readback");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule